// File: doc/BRIEF.md
# Cascaded Interrupt Priority Encoder

This block collects interrupt requests from three source groups (critical, main and peripheral), applies a per-source disable mask to each group, and folds the result into one 32-bit status word. Software reads that word to find the winning source in each group, and the block raises a single interrupt line to the processor. Each group fills its own valid flag and source code at fixed bit positions of the word. The lowest unmasked pending index wins inside a group.

Peripherals are folded into the two higher groups. A fixed set of peripheral sources is classed as high priority. Any unmasked pending peripheral of that class appears in the critical group as a reserved code. Any unmasked pending peripheral of the other class appears in the main group as a different reserved code. Software that sees one of these codes then reads the peripheral field. Peripheral source 0 is the summary request of a cascaded DMA channel group. The masks are loaded through a small write port. The status word is computed from the present requests and masks and is registered once.

Top module: `cirq_cascade_enc`

## Requirements
- R1: Status bit 10 is the critical valid flag and bits [9:8] hold the lowest-indexed critical source that is pending and unmasked. Critical mask bit n disables critical source n, and a 1 means disabled.
- R2: Status bit 21 is the main valid flag and bits [20:16] hold the lowest-indexed main source that is pending and unmasked. Main source n is disabled by main mask bit 16-n.
- R3: Status bit 29 is the peripheral valid flag and bits [28:24] hold the peripheral code. Peripheral source n is disabled by peripheral mask bit 31-n. If any unmasked high-class peripheral is pending (sources 0 and 1 by default), the code is the lowest such index. Otherwise it is the lowest unmasked pending low-class index.
- R4: Critical code 2 is reserved. Its pending bit is set exactly when an unmasked high-class peripheral is pending, and it still obeys critical mask bit 2. The critical request input at index 2 is ignored.
- R5: Main code 4 is reserved. Its pending bit is set exactly when an unmasked low-class peripheral is pending, and it still obeys main mask bit 12. The main request input at index 4 is ignored.
- R6: After reset the peripheral mask is 0x7FFFFC00, the main mask is 0x00010FFF and the critical mask is 0.
- R7: A write with select 0 loads the critical mask from the low data bits. Select 1 loads the main mask and select 2 loads the peripheral mask. Select 3 changes nothing. A loaded mask governs the status word that is registered at the following clock edge.
- R8: The status word is registered. After a clock edge it reflects the requests and masks that were present before that edge. During reset and after it, the word is 0 and the interrupt line is low.
- R9: The interrupt line equals the OR of the three valid flags of the registered status word, and it updates in the same cycle as the word.
- R10: When a group has no valid source, its code field reads 0. Every status bit outside the three fields reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| crit_req | input | 4 | Critical request vector; index 2 is ignored |
| main_req | input | 17 | Main request vector; index 4 is ignored |
| peri_req | input | 32 | Peripheral request vector; index 0 is the DMA summary |
| mask_wr_en | input | 1 | Mask write strobe |
| mask_wr_sel | input | 2 | Mask select: 0 critical, 1 main, 2 peripheral, 3 none |
| mask_wr_data | input | 32 | Mask write data |
| status_o | output | 32 | Registered encoded status word |
| cpu_irq_o | output | 1 | Interrupt line to the processor |

## Verification
The assertions assume that the request vectors are level signals and stay steady from one falling clock edge to the next. They also assume that the select value is meaningful only while the write strobe is high. The bench changes every request and every mask write at a falling edge and drops the strobe whenever it only applies requests. Reserved request bits and the unused select value are driven on purpose, so that the checks on ignored inputs see real activity on those inputs.

// File: rtl/cirq_pkg.sv
package cirq_pkg;

  localparam int STAT_W    = 32;
  localparam int CODE_W    = 5;
  localparam int CRIT_V    = 10;
  localparam int CRIT_LSB  = 8;
  localparam int MAIN_V    = 21;
  localparam int MAIN_LSB  = 16;
  localparam int PERI_V    = 29;
  localparam int PERI_LSB  = 24;

  typedef struct packed {
    logic              valid;
    logic [CODE_W-1:0] code;
  } grp_win_t;

  typedef enum logic [1:0] {
    SEL_CRIT = 2'd0,
    SEL_MAIN = 2'd1,
    SEL_PERI = 2'd2,
    SEL_NONE = 2'd3
  } mask_sel_e;

  // Lowest set index of a 32-bit vector.
  function automatic grp_win_t pick_lowest(input logic [31:0] vec);
    grp_win_t w;
    w = '0;
    for (int i = 31; i >= 0; i--) begin
      if (vec[i]) begin
        w.valid = 1'b1;
        w.code  = CODE_W'(i);
      end
    end
    return w;
  endfunction

  // Place the three group results into their fixed fields.
  function automatic logic [STAT_W-1:0] pack_status(
    input logic              cv,
    input logic [1:0]        cc,
    input logic              mv,
    input logic [CODE_W-1:0] mc,
    input logic              pv,
    input logic [CODE_W-1:0] pc
  );
    logic [STAT_W-1:0] s;
    s = '0;
    s[CRIT_V] = cv;
    s[CRIT_LSB +: 2] = cv ? cc : 2'd0;
    s[MAIN_V] = mv;
    s[MAIN_LSB +: CODE_W] = mv ? mc : '0;
    s[PERI_V] = pv;
    s[PERI_LSB +: CODE_W] = pv ? pc : '0;
    return s;
  endfunction

endpackage

// File: rtl/cirq_mask_regs.sv
module cirq_mask_regs
  import cirq_pkg::*;
#(
  parameter int NCRIT = 4,
  parameter int NMAIN = 17,
  parameter int NPERI = 32,
  parameter logic [NCRIT-1:0] CRIT_RST = '0,
  parameter logic [NMAIN-1:0] MAIN_RST = '1,
  parameter logic [NPERI-1:0] PERI_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [31:0]      wr_data,
  output logic [NCRIT-1:0] crit_mask,
  output logic [NMAIN-1:0] main_mask,
  output logic [NPERI-1:0] peri_mask
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crit_mask <= CRIT_RST;
      main_mask <= MAIN_RST;
      peri_mask <= PERI_RST;
    end else if (wr_en) begin
      case (mask_sel_e'(wr_sel))
        SEL_CRIT: crit_mask <= wr_data[NCRIT-1:0];
        SEL_MAIN: main_mask <= wr_data[NMAIN-1:0];
        SEL_PERI: peri_mask <= wr_data[NPERI-1:0];
        default:  ;
      endcase
    end
  end

  AST_NONE_SEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_sel == 2'd3) |=> ($stable(crit_mask) && $stable(main_mask) && $stable(peri_mask))); // R7
  AST_MAIN_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_sel == 2'd1) |=> (main_mask == $past(wr_data[NMAIN-1:0]))); // R7

endmodule

// File: rtl/cirq_group_enc.sv
module cirq_group_enc
  import cirq_pkg::*;
#(
  parameter int N = 32
) (
  input  logic [N-1:0] pend,
  output grp_win_t     win
);

  logic [31:0] padded;

  always_comb begin
    padded = '0;
    padded[N-1:0] = pend;
    win = pick_lowest(padded);
  end

  always_comb begin
    AST_WIN_IS_LOWEST: assert (!win.valid || (padded[win.code] && ((padded & ((32'd1 << win.code) - 32'd1)) == 32'd0))); // R1
  end

endmodule

// File: rtl/cirq_cascade_enc.sv
module cirq_cascade_enc
  import cirq_pkg::*;
#(
  parameter int NCRIT = 4,
  parameter int NMAIN = 17,
  parameter int NPERI = 32,
  parameter int HI_CRIT_CODE = 2,
  parameter int LO_MAIN_CODE = 4,
  parameter logic [NPERI-1:0] PERI_HI_SET   = 32'h0000_0003,
  parameter logic [NCRIT-1:0] CRIT_MASK_RST = '0,
  parameter logic [NMAIN-1:0] MAIN_MASK_RST = 17'h1_0FFF,
  parameter logic [NPERI-1:0] PERI_MASK_RST = 32'h7FFF_FC00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCRIT-1:0] crit_req,
  input  logic [NMAIN-1:0] main_req,
  input  logic [NPERI-1:0] peri_req,
  input  logic             mask_wr_en,
  input  logic [1:0]       mask_wr_sel,
  input  logic [31:0]      mask_wr_data,
  output logic [31:0]      status_o,
  output logic             cpu_irq_o
);

  localparam logic [NPERI-1:0] PERI_LO_SET = ~PERI_HI_SET;

  logic [NCRIT-1:0] crit_mask;
  logic [NMAIN-1:0] main_mask;
  logic [NPERI-1:0] peri_mask;

  logic [NMAIN-1:0] main_unmask;
  logic [NPERI-1:0] peri_unmask;
  logic [NPERI-1:0] peri_pend;
  logic [NCRIT-1:0] crit_eff;
  logic [NMAIN-1:0] main_eff;
  logic [NCRIT-1:0] crit_pend;
  logic [NMAIN-1:0] main_pend;

  grp_win_t crit_win, main_win, peri_hi_win, peri_lo_win, peri_win;
  logic     hi_any, lo_any;

  logic [31:0] status_d;
  logic [31:0] status_q;
  logic        irq_q;

  cirq_mask_regs #(
    .NCRIT(NCRIT), .NMAIN(NMAIN), .NPERI(NPERI),
    .CRIT_RST(CRIT_MASK_RST), .MAIN_RST(MAIN_MASK_RST), .PERI_RST(PERI_MASK_RST)
  ) u_masks (
    .clk(clk), .rst_n(rst_n),
    .wr_en(mask_wr_en), .wr_sel(mask_wr_sel), .wr_data(mask_wr_data),
    .crit_mask(crit_mask), .main_mask(main_mask), .peri_mask(peri_mask)
  );

  // Mask bits run in reverse order of the source index.
  for (genvar n = 0; n < NMAIN; n++) begin : g_main_rev
    assign main_unmask[n] = ~main_mask[NMAIN-1-n];
  end
  for (genvar n = 0; n < NPERI; n++) begin : g_peri_rev
    assign peri_unmask[n] = ~peri_mask[NPERI-1-n];
  end

  assign peri_pend = peri_req & peri_unmask;

  cirq_group_enc #(.N(NPERI)) u_peri_hi (.pend(peri_pend & PERI_HI_SET), .win(peri_hi_win));
  cirq_group_enc #(.N(NPERI)) u_peri_lo (.pend(peri_pend & PERI_LO_SET), .win(peri_lo_win));

  assign hi_any   = peri_hi_win.valid;
  assign lo_any   = peri_lo_win.valid;
  assign peri_win = peri_hi_win.valid ? peri_hi_win : peri_lo_win;

  // Reserved codes stand for the cascaded peripheral classes.
  for (genvar i = 0; i < NCRIT; i++) begin : g_crit_eff
    if (i == HI_CRIT_CODE) begin : g_casc
      assign crit_eff[i] = hi_any;
    end else begin : g_raw
      assign crit_eff[i] = crit_req[i];
    end
  end
  for (genvar i = 0; i < NMAIN; i++) begin : g_main_eff
    if (i == LO_MAIN_CODE) begin : g_casc
      assign main_eff[i] = lo_any;
    end else begin : g_raw
      assign main_eff[i] = main_req[i];
    end
  end

  assign crit_pend = crit_eff & ~crit_mask;
  assign main_pend = main_eff & main_unmask;

  cirq_group_enc #(.N(NCRIT)) u_crit (.pend(crit_pend), .win(crit_win));
  cirq_group_enc #(.N(NMAIN)) u_main (.pend(main_pend), .win(main_win));

  assign status_d = pack_status(crit_win.valid, crit_win.code[1:0],
                                main_win.valid, main_win.code,
                                peri_win.valid, peri_win.code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      irq_q    <= crit_win.valid | main_win.valid | peri_win.valid;
    end
  end

  assign status_o  = status_q;
  assign cpu_irq_o = irq_q;

  AST_IRQ_IS_OR: assert property (@(posedge clk) disable iff (!rst_n) cpu_irq_o == (status_q[CRIT_V] | status_q[MAIN_V] | status_q[PERI_V])); // R9
  AST_HI_CASCADE_HAS_PERI: assert property (@(posedge clk) disable iff (!rst_n) (status_q[CRIT_V] && status_q[CRIT_LSB +: 2] == 2'(HI_CRIT_CODE)) |-> status_q[PERI_V]); // R4
  AST_LO_CASCADE_HAS_PERI: assert property (@(posedge clk) disable iff (!rst_n) (status_q[MAIN_V] && status_q[MAIN_LSB +: CODE_W] == CODE_W'(LO_MAIN_CODE)) |-> status_q[PERI_V]); // R5
  AST_CRIT_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (crit_req[HI_CRIT_CODE] && !hi_any) |=> !(status_q[CRIT_V] && status_q[CRIT_LSB +: 2] == 2'(HI_CRIT_CODE))); // R4
  AST_MAIN_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (main_req[LO_MAIN_CODE] && !lo_any) |=> !(status_q[MAIN_V] && status_q[MAIN_LSB +: CODE_W] == CODE_W'(LO_MAIN_CODE))); // R5
  AST_CRIT_CODE_FITS: assert property (@(posedge clk) disable iff (!rst_n) crit_win.valid |-> (crit_win.code < CODE_W'(NCRIT))); // R1
  AST_EMPTY_FIELDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) ((status_q[CRIT_V] || status_q[CRIT_LSB +: 2] == 2'd0) && (status_q[MAIN_V] || status_q[MAIN_LSB +: CODE_W] == '0) && (status_q[PERI_V] || status_q[PERI_LSB +: CODE_W] == '0) && ((status_q & 32'hC0C0_F8FF) == 32'd0))); // R10

endmodule

// File: tb/tb_cirq_cascade_enc.sv
module tb_cirq_cascade_enc;

  localparam logic [31:0] HI_CLASS = 32'h0000_0003;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  crit_req = '0;
  logic [16:0] main_req = '0;
  logic [31:0] peri_req = '0;
  logic        mask_wr_en = 1'b0;
  logic [1:0]  mask_wr_sel = '0;
  logic [31:0] mask_wr_data = '0;
  logic [31:0] status_o;
  logic        cpu_irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [3:0]  m_cm = 4'h0;
  logic [16:0] m_mm = 17'h1_0FFF;
  logic [31:0] m_pm = 32'h7FFF_FC00;

  logic [32:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  cirq_cascade_enc dut (
    .clk(clk), .rst_n(rst_n),
    .crit_req(crit_req), .main_req(main_req), .peri_req(peri_req),
    .mask_wr_en(mask_wr_en), .mask_wr_sel(mask_wr_sel), .mask_wr_data(mask_wr_data),
    .status_o(status_o), .cpu_irq_o(cpu_irq_o)
  );

  // Reference: {irq, status} from requests and masks, written from the requirements.
  function automatic logic [32:0] model(input logic [3:0] c, input logic [16:0] m,
                                        input logic [31:0] p, input logic [3:0] cm,
                                        input logic [16:0] mm, input logic [31:0] pm);
    logic [31:0] s;
    logic hi, lo, cf, mf, pf;
    int hi_idx, lo_idx, pidx, cidx, midx;
    s = '0; hi = 0; lo = 0; hi_idx = -1; lo_idx = -1; cidx = -1; midx = -1;
    for (int n = 31; n >= 0; n--) begin
      if (p[n] && !pm[31-n]) begin
        if (HI_CLASS[n]) begin hi = 1; hi_idx = n; end
        else begin lo = 1; lo_idx = n; end
      end
    end
    for (int i = 3; i >= 0; i--) begin
      cf = (i == 2) ? hi : c[i];
      if (cf && !cm[i]) cidx = i;
    end
    for (int i = 16; i >= 0; i--) begin
      mf = (i == 4) ? lo : m[i];
      if (mf && !mm[16-i]) midx = i;
    end
    pidx = hi ? hi_idx : lo_idx;
    pf = (pidx >= 0);
    if (cidx >= 0) begin s[10] = 1; s[9:8] = 2'(cidx); end
    if (midx >= 0) begin s[21] = 1; s[20:16] = 5'(midx); end
    if (pf) begin s[29] = 1; s[28:24] = 5'(pidx); end
    return {(cidx >= 0) | (midx >= 0) | pf, s};
  endfunction

  task automatic apply(input logic [3:0] c, input logic [16:0] m, input logic [31:0] p, input string tag);
    @(negedge clk);
    mask_wr_en = 1'b0;
    crit_req = c; main_req = m; peri_req = p;
    exp_q.push_back(model(c, m, p, m_cm, m_mm, m_pm));
    tag_q.push_back(tag);
  endtask

  task automatic wmask(input logic [1:0] sel, input logic [31:0] data, input string tag);
    @(negedge clk);
    mask_wr_en = 1'b1; mask_wr_sel = sel; mask_wr_data = data;
    exp_q.push_back(model(crit_req, main_req, peri_req, m_cm, m_mm, m_pm));
    tag_q.push_back(tag);
    case (sel)
      2'd0: m_cm = data[3:0];
      2'd1: m_mm = data[16:0];
      2'd2: m_pm = data;
      default: ;
    endcase
  endtask

  // Monitor: compares one expected item per clock after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [32:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({cpu_irq_o, status_o} !== e) begin
          errors++;
          $display("FAIL %s: irq/status actual %0b/%08h expected %0b/%08h",
                   t, cpu_irq_o, status_o, e[32], e[31:0]);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (status_o !== 32'd0 || cpu_irq_o !== 1'b0) begin
      errors++;
      $display("FAIL R8: reset status actual %08h/%0b expected 00000000/0", status_o, cpu_irq_o);
    end
    rst_n = 1'b1;

    apply(4'b0000, '0, '0, "R10 idle word zero");
    apply(4'b1010, '0, '0, "R1 lowest critical");
    apply(4'b1000, '0, '0, "R1 critical source 3");
    apply(4'b0100, '0, '0, "R4 critical reserved input ignored");
    apply('0, 17'b01100, '0, "R2 lowest main");
    apply('0, 17'h0_0001, '0, "R6 main source 0 masked at reset");
    apply('0, 17'h0_0010, '0, "R5 main reserved input ignored");
    apply('0, '0, 32'h0200_0000, "R5 low peripheral cascades to main 4");
    apply('0, '0, 32'h0000_0001, "R4 DMA summary cascades to critical 2");
    apply('0, '0, 32'h0000_0020, "R6 peripheral 5 masked at reset");
    apply('0, '0, 32'h0080_0001, "R3 high class preferred");
    apply(4'b0001, 17'b00010, 32'h0080_0002, "R3 all groups together");
    wmask(2'd1, 32'h0, "R7 main write cycle");
    apply('0, 17'h0_0001, '0, "R7 main mask cleared");
    wmask(2'd3, 32'hFFFF_FFFF, "R7 select 3 cycle");
    apply('0, 17'h0_0001, '0, "R7 select 3 ignored");
    wmask(2'd0, 32'h4, "R4 mask critical 2");
    apply('0, '0, 32'h0000_0001, "R4 cascade masked, peripheral still valid");
    wmask(2'd1, 32'h0000_1000, "R5 mask main 4");
    apply('0, '0, 32'h0100_0000, "R5 cascade masked");
    wmask(2'd2, 32'hFFFF_FFFF, "R3 mask all peripherals");
    apply('0, '0, 32'hFFFF_FFFF, "R3 peripherals all masked");
    wmask(2'd2, 32'h0, "R3 unmask peripherals");
    apply('0, '0, 32'h0000_0400, "R3 peripheral 10 unmasked");
    apply(4'b1011, 17'h1_FFFF, 32'hFFFF_FFFC, "R9 irq with all groups");

    for (int k = 0; k < 400; k++) begin
      if (($urandom % 6) == 0)
        wmask(2'($urandom), $urandom & $urandom, "R7 random write");
      else
        apply(4'($urandom & $urandom), 17'($urandom & $urandom & $urandom),
              $urandom & $urandom & $urandom, "R3 random");
    end

    @(negedge clk);
    mask_wr_en = 1'b0;
    while (exp_q.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule